// File: doc/BRIEF.md
# PHY Management Serial Controller

This block lets software reach the registers of external Ethernet PHYs over the two-wire management bus. The bus has a clock line driven by the controller (MDC) and a bidirectional data line (MDIO). Software sees six word registers on a small write/read port. The configuration register sets the MDC divider. The address register holds the PHY number and the register number. The write data register starts a write transfer. The command register starts a read transfer. The read data register returns the captured value, and the status register exposes a busy flag that software polls.

Each transfer is one serial frame, sent MSB first. The frame is 32 preamble ones, start `01`, an opcode (`10` for read, `01` for write), the 5-bit PHY number, the 5-bit register number, a two-bit turnaround and 16 data bits. The controller changes MDIO only at MDC falling edges. During a read it releases MDIO from the turnaround onward and samples the PHY on MDC rising edges.

The two launch styles differ. A write starts as soon as the write data register is written. A read starts when bit 0 of the command register goes from 0 to 1, and software must write 0 to that bit before it can start another read.

Top module: `mii_mgmt_ctrl`

## Requirements
- R1: After reset, busy reads 0, MDC is low, MDIO is released, read data reads 0, and the configuration register reads 0x1C (divide by 28).
- R2: The register word index on `reg_addr` is: 0 configuration, 1 command, 2 address, 3 write data, 4 read data, 5 status (busy in bit 0). In the address register, bits 4:0 hold the register number and bits 12:8 hold the PHY number. All other bits of the address register read back as 0.
- R3: Writing the write data register while idle sends a frame of 32 ones, `01`, `01`, the PHY number, the register number, `10` and the 16 data bits, MSB first.
- R4: Writing 1 to command bit 0 while idle, when the stored bit is 0, sends a read frame with opcode `10`. While the stored bit stays 1, further writes of 1 start nothing.
- R5: In a read frame the controller releases MDIO for the two turnaround bits and the 16 data bits. It samples the data on MDC rising edges, and read data holds the 16 sampled bits once busy clears.
- R6: Busy reads 1 in the cycle after the launching write. It stays 1 for exactly 64 times the divide ratio in clock cycles, and it clears together with the last MDC falling edge.
- R7: Configuration bits 4:2 choose the divide ratio: 0→4, 1→4, 2→6, 3→8, 4→10, 5→14, 6→20, 7→28. MDC is high for half the ratio and low for half the ratio. The ratio is taken when a frame is launched.
- R8: Writes to the command or write data register while busy are discarded. Their readback values are unchanged and no extra frame follows.
- R9: While idle, MDC stays low and MDIO is released. The controller never changes MDIO at an MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data drive enable |
| mdio_i | input | 1 | Management data line as seen at the pin |

## Verification
Most faults inside this block show up on the serial line within one frame. A bit counter, shift register or opcode that goes wrong produces a frame that differs from the expected 64-bit frame the moment it completes. A bad divider or end-of-frame condition changes the busy duration, and the bench counts that duration to the cycle. Faulty gating of launches while busy shows up as a changed readback or an unexpected extra frame before the next operation. Sampling on the wrong MDC edge corrupts the returned read data.

// File: rtl/mii_mgmt_ctrl.sv
module mii_mgmt_ctrl #(
  parameter int PRE_BITS = 32,
  parameter logic [2:0] RESET_SEL = 3'd7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] TA_BIT   = BIT_W'(FRAME_BITS - 18);
  localparam logic [BIT_W-1:0] DATA_BIT = BIT_W'(FRAME_BITS - 16);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [2:0] A_CFG = 3'd0, A_CMD = 3'd1, A_ADDR = 3'd2,
                         A_WDAT = 3'd3, A_RDAT = 3'd4, A_STAT = 3'd5;

  logic [2:0]            sel_q;
  logic                  cmd_q;
  logic [4:0]            reg_q, phy_q;
  logic [15:0]           wdata_q, rdata_q, in_q;
  logic                  busy, is_rd, mdc_q;
  logic [3:0]            half_q, cnt_q;
  logic [BIT_W-1:0]      bit_q;
  logic [FRAME_BITS-1:0] sh_q;

  wire wr_cfg  = reg_we && reg_addr == A_CFG;
  wire wr_cmd  = reg_we && reg_addr == A_CMD;
  wire wr_addr = reg_we && reg_addr == A_ADDR;
  wire wr_wdat = reg_we && reg_addr == A_WDAT;
  wire go_wr   = wr_wdat && !busy;
  wire go_rd   = wr_cmd && !busy && reg_wdata[0] && !cmd_q;
  wire edge_now = cnt_q == half_q - 4'd1;

  logic unused_ok;
  assign unused_ok = ^{reg_wdata[31:16], reg_wdata[7:5], reg_wdata[1]};

  function automatic logic [3:0] half_of(input logic [2:0] s);
    case (s)
      3'd0, 3'd1: half_of = 4'd2;
      3'd2:       half_of = 4'd3;
      3'd3:       half_of = 4'd4;
      3'd4:       half_of = 4'd5;
      3'd5:       half_of = 4'd7;
      3'd6:       half_of = 4'd10;
      default:    half_of = 4'd14;
    endcase
  endfunction

  function automatic logic [FRAME_BITS-1:0] build(input logic rd, input logic [4:0] pa,
                                                  input logic [4:0] ra, input logic [15:0] d);
    build = {{PRE_BITS{1'b1}}, 2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= RESET_SEL;
      cmd_q   <= 1'b0;
      reg_q   <= '0;
      phy_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      in_q    <= '0;
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      mdc_q   <= 1'b0;
      half_q  <= 4'd2;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      if (wr_cfg) sel_q <= reg_wdata[4:2];
      if (wr_addr) begin
        reg_q <= reg_wdata[4:0];
        phy_q <= reg_wdata[12:8];
      end
      if (wr_cmd && !busy) cmd_q <= reg_wdata[0];
      if (go_wr) wdata_q <= reg_wdata[15:0];
      if (go_wr || go_rd) begin
        busy   <= 1'b1;
        is_rd  <= go_rd;
        mdc_q  <= 1'b0;
        cnt_q  <= '0;
        bit_q  <= '0;
        half_q <= half_of(sel_q);
        sh_q   <= build(go_rd, phy_q, reg_q, go_rd ? 16'h0000 : reg_wdata[15:0]);
      end else if (busy) begin
        if (edge_now) begin
          cnt_q <= '0;
          mdc_q <= !mdc_q;
          if (!mdc_q) begin
            if (is_rd && bit_q >= DATA_BIT) in_q <= {in_q[14:0], mdio_i};
          end else if (bit_q == LAST_BIT) begin
            busy <= 1'b0;
            if (is_rd) rdata_q <= in_q;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
          end
        end else begin
          cnt_q <= cnt_q + 4'd1;
        end
      end
    end
  end

  assign mdc     = mdc_q;
  assign mdio_oe = busy && !(is_rd && bit_q >= TA_BIT);
  assign mdio_o  = mdio_oe && sh_q[FRAME_BITS-1];

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {27'd0, sel_q, 2'b00};
      A_CMD:   reg_rdata = {31'd0, cmd_q};
      A_ADDR:  reg_rdata = {19'd0, phy_q, 3'b000, reg_q};
      A_WDAT:  reg_rdata = {16'd0, wdata_q};
      A_RDAT:  reg_rdata = {16'd0, rdata_q};
      A_STAT:  reg_rdata = {31'd0, busy};
      default: reg_rdata = 32'd0;
    endcase
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R9
  AST_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R9
  AST_END_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc)); // R6
  AST_BUSY_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == A_WDAT) |=> $stable(wdata_q)); // R8
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CMD && reg_wdata[0] && cmd_q && !busy) |=> !busy); // R4
endmodule

// File: tb/mii_mgmt_ctrl_test.sv
module mii_mgmt_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;
  logic phy_oe = 1'b0, phy_o = 1'b0;

  int checks = 0, failures = 0, frames_seen = 0, frames_pushed = 0, rc = 0;
  bit done = 1'b0, oe_viol = 1'b0;
  logic [63:0] capv = '0;
  logic [63:0] exp_q[$];
  logic [15:0] phy_mem [32];
  logic [15:0] exp_mem [32];

  always #5 clk = !clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  mii_mgmt_ctrl uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY model and scoreboard monitor
  always @(posedge mdc) begin
    capv[63-rc] = mdio_i;
    if (rc >= 46 && capv[29:28] == 2'b10 && mdio_oe) oe_viol = 1'b1;
    rc++;
    if (rc == 64) begin
      frames_seen++;
      if (capv[29:28] == 2'b01) phy_mem[capv[22:18]] = capv[15:0];
      if (exp_q.size() == 0) chk("R8 unexpected frame", 32'd1, 32'd0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk("R3/R4 frame hi", capv[63:32], e[63:32]);
        chk("R3/R5 frame lo", capv[31:0], e[31:0]);
      end
    end
  end

  always @(negedge mdc) begin
    if (rc >= 36 && rc < 64 && capv[29:28] == 2'b10 && rc >= 47) begin
      phy_oe = 1'b1;
      phy_o  = (rc == 47) ? 1'b0 : phy_mem[capv[22:18]][63-rc];
    end else begin
      phy_oe = 1'b0;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    rd(3'd5, v);
    while (v[0] && n < 5000) begin
      n++;
      @(negedge clk);
      rd(3'd5, v);
    end
  endtask

  task automatic mii_write(input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] d, input int exp_cycles);
    int n;
    logic [31:0] v;
    wr(3'd2, {19'd0, pa, 3'd0, ra});
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, d});
    frames_pushed++;
    exp_mem[ra] = d;
    rc = 0;
    wr(3'd3, {16'd0, d});
    rd(3'd5, v);
    chk("R6 busy after launch", v, 32'd1);
    wait_idle(n);
    if (exp_cycles > 0) chk("R6/R7 busy length", n, exp_cycles);
  endtask

  task automatic mii_read(input logic [4:0] pa, input logic [4:0] ra, input int exp_cycles);
    int n;
    logic [31:0] v;
    wr(3'd2, {19'd0, pa, 3'd0, ra});
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 2'b10, exp_mem[ra]});
    frames_pushed++;
    rc = 0;
    wr(3'd1, 32'd1);
    wait_idle(n);
    if (exp_cycles > 0) chk("R6 read busy length", n, exp_cycles);
    rd(3'd4, v);
    chk("R5 read data", v, {16'd0, exp_mem[ra]});
    wr(3'd1, 32'd0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    for (int i = 0; i < 32; i++) begin phy_mem[i] = 16'h0; exp_mem[i] = 16'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd5, v); chk("R1 busy reset", v, 32'd0);
    rd(3'd0, v); chk("R1 cfg reset", v, 32'h1C);
    rd(3'd4, v); chk("R1 rdata reset", v, 32'd0);
    chk("R1 mdc low", {31'd0, mdc}, 32'd0);
    chk("R1 mdio released", {31'd0, mdio_oe}, 32'd0);

    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R2 addr mask", v, 32'h0000_1F1F);
    wr(3'd0, 32'h0000_0000);
    rd(3'd0, v); chk("R7 cfg sel0", v, 32'd0);

    mii_write(5'd5, 5'd3, 16'hA5C3, 256);
    mii_read(5'd5, 5'd3, 256);
    mii_write(5'd31, 5'd0, 16'h8001, 256);
    mii_read(5'd31, 5'd0, 256);
    mii_write(5'd0, 5'd31, 16'hFFFF, 256);
    mii_read(5'd0, 5'd31, 0);
    mii_write(5'd9, 5'd7, 16'h0000, 256);
    mii_read(5'd9, 5'd7, 0);

    // R8: writes while busy are dropped
    wr(3'd2, {19'd0, 5'd2, 3'd0, 5'd4});
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b01, 5'd2, 5'd4, 2'b10, 16'h1234});
    frames_pushed++;
    exp_mem[4] = 16'h1234;
    rc = 0;
    wr(3'd3, 32'h1234);
    wr(3'd3, 32'hBEEF);
    wr(3'd1, 32'd1);
    wait_idle(n);
    rd(3'd3, v); chk("R8 wdata kept", v, 32'h1234);
    rd(3'd1, v); chk("R8 cmd kept", v, 32'd0);
    repeat (20) @(negedge clk);
    chk("R8 frame count", frames_seen, frames_pushed);
    mii_read(5'd2, 5'd4, 256);

    // R4: no relaunch while command bit stays set
    wr(3'd2, {19'd0, 5'd1, 3'd0, 5'd3});
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b10, 5'd1, 5'd3, 2'b10, exp_mem[3]});
    frames_pushed++;
    rc = 0;
    wr(3'd1, 32'd1);
    wait_idle(n);
    wr(3'd1, 32'd1);
    rd(3'd5, v); chk("R4 no rearm", v, 32'd0);
    repeat (40) @(negedge clk);
    chk("R4 frame count", frames_seen, frames_pushed);
    wr(3'd1, 32'd0);

    // R7: other divide ratios
    wr(3'd0, 32'h0000_000C);
    mii_write(5'd3, 5'd10, 16'h5A5A, 512);
    wr(3'd0, 32'h0000_001C);
    mii_write(5'd3, 5'd11, 16'hC001, 1792);
    wr(3'd0, 32'h0000_0014);
    wr(3'd2, {19'd0, 5'd3, 3'd0, 5'd12});
    exp_q.push_back({32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd12, 2'b10, 16'h0F0F});
    frames_pushed++;
    exp_mem[12] = 16'h0F0F;
    rc = 0;
    wr(3'd3, 32'h0F0F);
    @(posedge mdc);
    n = 0;
    @(negedge clk);
    while (mdc && n < 100) begin n++; @(negedge clk); end
    chk("R7 mdc high half", n, 7);
    wait_idle(n);
    mii_read(5'd3, 5'd12, 896);

    repeat (20) @(negedge clk);
    chk("R5 turnaround released", {31'd0, oe_viol}, 32'd0);
    chk("R3 all frames seen", frames_seen, frames_pushed);
    chk("R9 idle mdc", {31'd0, mdc}, 32'd0);
    chk("R9 idle mdio", {31'd0, mdio_oe}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule